// File: doc/BRIEF.md
# Angle-Compare Triggered One-Shot Channel

This block is one output channel for an ignition coil or fuel injector driver. A host writes two 16-bit values into the channel: the engine angle at which the output should fire, and the length of the output pulse. A shared angle bus, driven by the crank or cam position counter, is watched every clock. When the bus value is exactly equal to the stored firing angle, the channel loads a down-counter with the pulse length and drives its output active.

The down-counter steps once every two system clocks. A toggle flop produces the enable for those steps. When the counter reaches zero the output drops and the comparator arms again, so the channel can fire on the next revolution. While a pulse is running the comparator is blind. Register writes made during a pulse apply only from the next firing onward. A busy flag and readback of both registers let the host observe the channel.

Top module: `angle_oneshot_chan`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pulse_o` and `busy_o` are 0 and both readback registers are 0. The half-rate toggle is 0 on the first clock edge after reset.
- R2: A high `cmp_wr_i` at a clock edge stores `cmp_data_i`, and the stored value appears on `cmp_rd_o` in the next cycle. A high `width_wr_i` does the same with `width_data_i` and `width_rd_o`.
- R3: When the channel is armed (`busy_o` = 0), `angle_i` equals the stored compare value exactly, and the stored width is nonzero, then `busy_o` and `pulse_o` are 1 in the next cycle. At that edge the counter is loaded with the stored width, whatever the toggle phase.
- R4: The half-rate toggle inverts on every clock edge after reset. While the channel is firing, the counter decrements only at edges where the toggle is 1, so a width of W gives a pulse of 2W-1 or 2W cycles.
- R5: At the edge where the counter steps from 1 to 0, the channel stops firing, so `pulse_o` and `busy_o` are 0 in the next cycle. With `angle_i` held at the compare value, the channel fires again after exactly one low cycle.
- R6: While `busy_o` is 1, a match on `angle_i` neither restarts nor extends the running pulse.
- R7: A stored width of 0 stops a match from firing the channel. `busy_o` stays 0 and the channel stays armed.
- R8: Writes made while a pulse runs do not change its length. A match in the same cycle as a compare write is tested against the old compare value and loads the old width.
- R9: `busy_o` is 1 exactly while a pulse is in progress and 0 while the channel is armed, and `pulse_o` follows the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| angle_i | input | ANGLE_W | Shared engine angle bus |
| cmp_wr_i | input | 1 | Write strobe for the firing angle |
| cmp_data_i | input | ANGLE_W | Firing angle write data |
| width_wr_i | input | 1 | Write strobe for the pulse width |
| width_data_i | input | WIDTH_W | Pulse width write data, in half-rate ticks |
| cmp_rd_o | output | ANGLE_W | Readback of the stored firing angle |
| width_rd_o | output | WIDTH_W | Readback of the stored pulse width |
| busy_o | output | 1 | 1 while a pulse runs, 0 while armed |
| pulse_o | output | 1 | Driver output, active high |

## Verification
The bench builds the channel with the default 16-bit angle and width. Random widths are kept between 0 and 8, so hundreds of pulses complete in a short run. Both toggle phases occur at the trigger edge, which exercises the 2W-1 and 2W pulse lengths. The occasional zero width and the register writes during pulses land in every part of a pulse. A per-cycle reference model checks the outputs. Directed cases cover the exact-match edge, back-to-back refiring with the angle held, and writes coinciding with a match.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_FIRING = 1'b1
  } chan_st_e;
endpackage

// File: rtl/chan_half_rate.sv
module chan_half_rate (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= ~tick_o;
  end
endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs #(
  parameter int AW = 16,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_wr_i,
  input  logic [AW-1:0] cmp_data_i,
  input  logic          width_wr_i,
  input  logic [WW-1:0] width_data_i,
  output logic [AW-1:0] cmp_q_o,
  output logic [WW-1:0] width_q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q_o   <= '0;
      width_q_o <= '0;
    end else begin
      if (cmp_wr_i)   cmp_q_o   <= cmp_data_i;
      if (width_wr_i) width_q_o <= width_data_i;
    end
  end
endmodule

// File: rtl/chan_angle_cmp.sv
module chan_angle_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] angle_i,
  input  logic [AW-1:0] ref_i,
  output logic          hit_o
);
  always_comb hit_o = (angle_i == ref_i);
endmodule

// File: rtl/chan_pulse_timer.sv
module chan_pulse_timer
  import chan_pkg::*;
#(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_i,
  input  logic [WW-1:0] width_i,
  input  logic          tick_i,
  output logic          busy_o,
  output logic          pulse_o,
  output logic [WW-1:0] cnt_o
);
  localparam logic [WW-1:0] ONE = WW'(1);

  chan_st_e st_q;
  logic     fire;
  logic     last_step;

  always_comb begin
    fire      = (st_q == ST_ARMED) && hit_i && (width_i != '0);
    last_step = (st_q == ST_FIRING) && tick_i && (cnt_o == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_ARMED;
      cnt_o   <= '0;
      pulse_o <= 1'b0;
    end else if (fire) begin
      st_q    <= ST_FIRING;
      cnt_o   <= width_i;
      pulse_o <= 1'b1;
    end else if (st_q == ST_FIRING && tick_i) begin
      cnt_o <= cnt_o - ONE;
      if (last_step) begin
        st_q    <= ST_ARMED;
        pulse_o <= 1'b0;
      end
    end
  end

  always_comb busy_o = (st_q == ST_FIRING);
endmodule

// File: rtl/angle_oneshot_chan.sv
module angle_oneshot_chan #(
  parameter int ANGLE_W = 16,
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               cmp_wr_i,
  input  logic [ANGLE_W-1:0] cmp_data_i,
  input  logic               width_wr_i,
  input  logic [WIDTH_W-1:0] width_data_i,
  output logic [ANGLE_W-1:0] cmp_rd_o,
  output logic [WIDTH_W-1:0] width_rd_o,
  output logic               busy_o,
  output logic               pulse_o
);
  logic               tick_w;
  logic               hit_w;
  logic [WIDTH_W-1:0] cnt_w;

  chan_half_rate u_rate (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_w)
  );

  chan_cfg_regs #(.AW(ANGLE_W), .WW(WIDTH_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cmp_wr_i     (cmp_wr_i),
    .cmp_data_i   (cmp_data_i),
    .width_wr_i   (width_wr_i),
    .width_data_i (width_data_i),
    .cmp_q_o      (cmp_rd_o),
    .width_q_o    (width_rd_o)
  );

  chan_angle_cmp #(.AW(ANGLE_W)) u_cmp (
    .angle_i (angle_i),
    .ref_i   (cmp_rd_o),
    .hit_o   (hit_w)
  );

  chan_pulse_timer #(.WW(WIDTH_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (hit_w),
    .width_i (width_rd_o),
    .tick_i  (tick_w),
    .busy_o  (busy_o),
    .pulse_o (pulse_o),
    .cnt_o   (cnt_w)
  );
endmodule

// File: rtl/chan_sva.sv
module chan_sva #(
  parameter int AW = 16,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] angle_i,
  input logic          cmp_wr_i,
  input logic [AW-1:0] cmp_data_i,
  input logic [AW-1:0] cmp_rd_o,
  input logic [WW-1:0] width_rd_o,
  input logic          busy_o,
  input logic          pulse_o,
  input logic [WW-1:0] cnt,
  input logic          tick
);
  // R2: compare write lands in the readback
  a_r2_cmp_write: assert property (@(posedge clk) disable iff (rst)
    cmp_wr_i |=> cmp_rd_o == $past(cmp_data_i));

  // R3: armed exact match with nonzero width fires
  a_r3_fire: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && angle_i == cmp_rd_o && width_rd_o != '0) |=> (busy_o && pulse_o && cnt == $past(width_rd_o)));

  // R4: no decrement on two consecutive edges
  a_r4_half_rate: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && $past(busy_o, 2)) |->
      !((cnt != $past(cnt)) && ($past(cnt) != $past(cnt, 2))));

  // R5: last step drops the output
  a_r5_end: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick && cnt == WW'(1)) |=> (!busy_o && !pulse_o));

  // R6: on a non-step cycle the running count holds despite any match
  a_r6_no_reload: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick) |=> (busy_o && cnt == $past(cnt)));

  // R7: zero width never fires
  a_r7_zero_width: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && width_rd_o == '0) |=> !busy_o);

  // R9: output and busy flag agree
  a_r9_pulse_busy: assert property (@(posedge clk) disable iff (rst)
    pulse_o == busy_o);
endmodule

bind angle_oneshot_chan chan_sva #(.AW(ANGLE_W), .WW(WIDTH_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .angle_i    (angle_i),
  .cmp_wr_i   (cmp_wr_i),
  .cmp_data_i (cmp_data_i),
  .cmp_rd_o   (cmp_rd_o),
  .width_rd_o (width_rd_o),
  .busy_o     (busy_o),
  .pulse_o    (pulse_o),
  .cnt        (cnt_w),
  .tick       (tick_w)
);

// File: tb/tb_angle_oneshot_chan.sv
module tb_angle_oneshot_chan;
  localparam int AW = 16;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] angle_i = '0;
  logic          cmp_wr_i = 1'b0;
  logic [AW-1:0] cmp_data_i = '0;
  logic          width_wr_i = 1'b0;
  logic [WW-1:0] width_data_i = '0;
  logic [AW-1:0] cmp_rd_o;
  logic [WW-1:0] width_rd_o;
  logic          busy_o;
  logic          pulse_o;

  always #4 clk = ~clk;

  angle_oneshot_chan #(.ANGLE_W(AW), .WIDTH_W(WW)) dut (
    .clk(clk), .rst(rst), .angle_i(angle_i),
    .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
    .width_wr_i(width_wr_i), .width_data_i(width_data_i),
    .cmp_rd_o(cmp_rd_o), .width_rd_o(width_rd_o),
    .busy_o(busy_o), .pulse_o(pulse_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  logic          m_tick = 1'b0;
  logic          m_busy = 1'b0;
  logic [WW-1:0] m_cnt = '0;
  logic [AW-1:0] m_cmp = '0;
  logic [WW-1:0] m_wid = '0;

  // pulse shape tracking
  int  hi_run = 0, lo_run = 0, last_len = 0, last_gap = 0;
  bit  prev_p = 1'b0, seen_fall = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_edge(input logic [AW-1:0] ang, input logic cw, input logic [AW-1:0] cd,
                                     input logic ww, input logic [WW-1:0] wd);
    logic fire;
    fire = !m_busy && (ang == m_cmp) && (m_wid != '0);
    if (fire) begin
      m_cnt  = m_wid;
      m_busy = 1'b1;
    end else if (m_busy && m_tick) begin
      if (m_cnt == WW'(1)) m_busy = 1'b0;
      m_cnt = m_cnt - WW'(1);
    end
    if (cw) m_cmp = cd;
    if (ww) m_wid = wd;
    m_tick = ~m_tick;
  endfunction

  task automatic step(input logic [AW-1:0] ang, input logic cw, input logic [AW-1:0] cd,
                      input logic ww, input logic [WW-1:0] wd);
    angle_i = ang; cmp_wr_i = cw; cmp_data_i = cd; width_wr_i = ww; width_data_i = wd;
    model_edge(ang, cw, cd, ww, wd);
    @(negedge clk);
    chk(tag, "pulse_o", 32'(pulse_o), 32'(m_busy));
    chk(tag, "busy_o", 32'(busy_o), 32'(m_busy));
    chk(tag, "cmp_rd_o", 32'(cmp_rd_o), 32'(m_cmp));
    chk(tag, "width_rd_o", 32'(width_rd_o), 32'(m_wid));
    if (pulse_o) begin
      if (!prev_p && seen_fall) last_gap = lo_run;
      hi_run++; lo_run = 0;
    end else begin
      if (prev_p) begin last_len = hi_run; hi_run = 0; seen_fall = 1'b1; end
      lo_run++;
    end
    prev_p = pulse_o;
  endtask

  task automatic idle(input logic [AW-1:0] ang, input int n);
    for (int k = 0; k < n; k++) step(ang, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0417);
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    chk(tag, "pulse_o", 32'(pulse_o), 0);
    chk(tag, "busy_o", 32'(busy_o), 0);
    chk(tag, "cmp_rd_o", 32'(cmp_rd_o), 0);
    chk(tag, "width_rd_o", 32'(width_rd_o), 0);
    rst = 1'b0;
    idle(16'h0000, 2); // width 0 so angle 0 == cmp 0 does not fire (R1, R7)

    tag = "R2 writes";
    step(16'h1234, 1'b1, 16'h0100, 1'b1, 16'd3);
    chk("R2", "cmp readback", 32'(cmp_rd_o), 32'h0100);
    chk("R2", "width readback", 32'(width_rd_o), 32'd3);

    tag = "R3 R4 R9 sweep";
    for (int a = 16'h00F8; a < 16'h0110; a++) step(16'(a), 1'b0, '0, 1'b0, '0);
    idle(16'h0200, 4);
    chk("R4", "pulse length 2W-1..2W", 32'((last_len == 5) || (last_len == 6)), 1);

    tag = "R7 zero width";
    step(16'h0200, 1'b0, '0, 1'b1, 16'd0);
    idle(16'h0100, 6);
    chk("R7", "busy with zero width", 32'(busy_o), 0);

    tag = "R6 R8 writes in pulse";
    step(16'h0200, 1'b0, '0, 1'b1, 16'd4);
    step(16'h0100, 1'b0, '0, 1'b0, '0);
    step(16'h0100, 1'b1, 16'h0300, 1'b1, 16'd1);
    idle(16'h0100, 3);
    chk("R6", "still busy after matches", 32'(busy_o), 1);
    idle(16'h0100, 8);
    chk("R8", "pulse length kept 7..8", 32'((last_len == 7) || (last_len == 8)), 1);

    tag = "R8 write with match";
    step(16'h0300, 1'b1, 16'h0400, 1'b1, 16'd2);
    chk("R8", "match on old value fires", 32'(busy_o), 1);
    idle(16'h0000, 4);

    tag = "R5 refire";
    idle(16'h0400, 16);
    chk("R5", "one low cycle between pulses", 32'(last_gap), 1);
    chk("R5", "refire length 3..4", 32'((last_len == 3) || (last_len == 4)), 1);

    tag = "R3 R4 R5 R6 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] ang;
      logic cw, ww;
      ang = ($urandom % 4 == 0) ? m_cmp : AW'($urandom);
      cw  = ($urandom % 20 == 0);
      ww  = ($urandom % 12 == 0);
      step(ang, cw, AW'($urandom), ww, WW'($urandom % 9));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule